// File: doc/BRIEF.md
# Trunk Member Port Selector

This block picks the physical egress port for a frame whose destination port falls inside a link aggregation group. Sixteen ports form four fixed groups of four neighbouring ports, and a separate enable turns each group on or off. For a frame aimed at a port of an enabled group, a two-bit fold of the destination and source MAC addresses picks one member. A given address pair therefore always leaves on the same link, so frames are neither reordered nor duplicated. Destinations in a disabled group pass through unchanged.

The block also watches the per-port link bits. If any member of an enabled group loses its link, the whole group is treated as faulted. All four of its ports are reported down, and frames aimed at that group are flagged for drop. Each group drives an active-low status LED through a four-state machine. The LED is dark while the group is disabled, lit steadily while the group is healthy, and blinks in equal lit and unlit intervals while the group is faulted. The interval length comes from the clock rate and the blink period given as parameters.

The LED machine has four states. LED_DARK is left for LED_SOLID when the group is enabled and healthy ("enable"), or for LED_BLINK_LIT when it is enabled and faulted ("fault"). LED_SOLID moves to LED_BLINK_LIT on "fault". LED_BLINK_LIT and LED_BLINK_UNLIT swap on each interval expiry ("tick"). Either blink state moves to LED_SOLID when every member link returns ("recover"). Every state returns to LED_DARK when the group enable drops ("disable").

Top module: `trunk_port_selector`

## Requirements
- R1: When `dst_port` lies in an enabled, healthy group g (ports 4g to 4g+3), `egress_port` equals 4g plus the two-bit hash index and `drop` is 0, combinationally.
- R2: Address bit n is serial transmission bit n (`da[n]`, `sa[n]`). Index bit 0 is the XOR of da bits 47,45,43,41,39,37,35,33 and sa bits 46,44,42,40,38,36,34,32.
- R3: Index bit 1 is the XOR of sa bits 47,45,43,41,39,37,35,33 and da bits 46,44,42,40,38,36,34,32. No other address bit affects the index.
- R4: For a fixed address pair, every destination port inside the same enabled group yields the same `egress_port`.
- R5: When the destination's group is disabled, `egress_port` equals `dst_port` and `drop` is 0.
- R6: For an enabled group with any member link down, all four bits of that group in `link_rpt` are 0 and its `grp_up` bit is 0. For a healthy enabled group, `grp_up` is 1 and `link_rpt` equals `link_up`. For a disabled group, `link_rpt` equals `link_up` and `grp_up` is 0.
- R7: When the destination's group is enabled and faulted, `drop` is 1 and `egress_port` equals `dst_port`.
- R8: After reset, and one clock after a group's enable drops, that group's `led_n` bit is 1 (dark).
- R9: One clock after a group is enabled and healthy, its `led_n` bit is 0 and stays 0.
- R10: One clock after an enabled group becomes faulted, its `led_n` bit goes 0 for exactly BLINK_CYCLES = CLK_KHZ*BLINK_MS clocks, then 1 for BLINK_CYCLES, and keeps alternating.
- R11: One clock after a blinking group's links all recover, its `led_n` bit is 0 steadily.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trunk_en | input | 4 | Per-group enable, bit g for ports 4g..4g+3 |
| link_up | input | 16 | Per-port link state, 1 = up |
| dst_port | input | 4 | Destination port from lookup |
| da | input | 48 | Destination MAC, bit n = serial bit n |
| sa | input | 48 | Source MAC, bit n = serial bit n |
| egress_port | output | 4 | Chosen physical egress port |
| drop | output | 1 | Destination group faulted, discard frame |
| link_rpt | output | 16 | Per-port link as reported after group fault masking |
| grp_up | output | 4 | Per-group enabled and healthy |
| led_n | output | 4 | Per-group active-low status LED |

## Verification
A wrong hash bit shows at once on `egress_port` as a member off by one or two within the correct group. Patterns that set single address bits expose it in the same cycle. A stuck fault detector shows combinationally on `link_rpt`, `grp_up` and `drop` when one member link falls. A wrong LED state or a wrong interval counter shows one clock after the enable or fault changes. It appears as a wrong steady level or as a lit or unlit run that differs from BLINK_CYCLES in the first full blink period.

// File: rtl/trunk_sel_pkg.sv
package trunk_sel_pkg;
    typedef enum logic [1:0] {
        LED_DARK,
        LED_SOLID,
        LED_BLINK_LIT,
        LED_BLINK_UNLIT
    } led_state_t;
endpackage

// File: rtl/trunk_hash.sv
module trunk_hash #(
    parameter int ADDR_W    = 48,
    parameter int FOLD_BITS = 8
) (
    input  logic [ADDR_W-1:0] da,
    input  logic [ADDR_W-1:0] sa,
    output logic [1:0]        idx
);
    // Alternate bits from the top of each address: odd positions of one
    // address fold with even positions of the other.
    always_comb begin
        idx = '0;
        for (int i = 0; i < FOLD_BITS; i++) begin
            idx[0] = idx[0] ^ da[ADDR_W-1-2*i] ^ sa[ADDR_W-2-2*i];
            idx[1] = idx[1] ^ sa[ADDR_W-1-2*i] ^ da[ADDR_W-2-2*i];
        end
    end
endmodule

// File: rtl/trunk_health.sv
module trunk_health #(
    parameter int GROUPS  = 4,
    parameter int MEMBERS = 4,
    localparam int PORTS  = GROUPS * MEMBERS
) (
    input  logic [GROUPS-1:0] trunk_en,
    input  logic [PORTS-1:0]  link_up,
    output logic [GROUPS-1:0] grp_up,
    output logic [GROUPS-1:0] grp_fault,
    output logic [PORTS-1:0]  link_rpt
);
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic all_up;
        assign all_up       = &link_up[g*MEMBERS +: MEMBERS];
        assign grp_up[g]    = trunk_en[g] & all_up;
        assign grp_fault[g] = trunk_en[g] & ~all_up;
        assign link_rpt[g*MEMBERS +: MEMBERS] =
            grp_fault[g] ? '0 : link_up[g*MEMBERS +: MEMBERS];
    end
endmodule

// File: rtl/trunk_led.sv
module trunk_led
    import trunk_sel_pkg::*;
#(
    parameter int BLINK_CYCLES = 12_500_000,
    localparam int CW = $clog2(BLINK_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic fault,
    output logic led_n
);
    led_state_t state, nxt;
    logic [CW-1:0] cnt;
    logic tick, blinking;

    assign tick     = (cnt == CW'(BLINK_CYCLES - 1));
    assign blinking = (state == LED_BLINK_LIT) || (state == LED_BLINK_UNLIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LED_DARK;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            LED_DARK: begin
                if (en && fault)       nxt = LED_BLINK_LIT;
                else if (en)           nxt = LED_SOLID;
            end
            LED_SOLID: begin
                if (!en)               nxt = LED_DARK;
                else if (fault)        nxt = LED_BLINK_LIT;
            end
            LED_BLINK_LIT: begin
                if (!en)               nxt = LED_DARK;
                else if (!fault)       nxt = LED_SOLID;
                else if (tick)         nxt = LED_BLINK_UNLIT;
            end
            LED_BLINK_UNLIT: begin
                if (!en)               nxt = LED_DARK;
                else if (!fault)       nxt = LED_SOLID;
                else if (tick)         nxt = LED_BLINK_LIT;
            end
            default:                   nxt = LED_DARK;
        endcase
    end

    // Interval counter runs only while blinking; restarts on each state change.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         cnt <= '0;
        else if (!blinking || nxt != state) cnt <= '0;
        else                                cnt <= cnt + 1'b1;
    end

    always_comb begin
        led_n = 1'b1;
        unique case (state)
            LED_SOLID, LED_BLINK_LIT: led_n = 1'b0;
            default:                  led_n = 1'b1;
        endcase
    end

    assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(BLINK_CYCLES));
    assert_dark_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> led_n);
    assert_solid_when_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !fault) |=> !led_n);
    assert_blink_starts_lit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && fault && !blinking) |=> !led_n);
endmodule

// File: rtl/trunk_port_selector.sv
module trunk_port_selector #(
    parameter int CLK_KHZ  = 50_000,
    parameter int BLINK_MS = 250,
    parameter int GROUPS   = 4,
    parameter int MEMBERS  = 4,
    parameter int ADDR_W   = 48,
    localparam int PORTS   = GROUPS * MEMBERS,
    localparam int PORT_W  = $clog2(PORTS),
    localparam int MEM_W   = $clog2(MEMBERS),
    localparam int GRP_W   = PORT_W - MEM_W,
    localparam int BLINK_CYCLES = CLK_KHZ * BLINK_MS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GROUPS-1:0] trunk_en,
    input  logic [PORTS-1:0]  link_up,
    input  logic [PORT_W-1:0] dst_port,
    input  logic [ADDR_W-1:0] da,
    input  logic [ADDR_W-1:0] sa,
    output logic [PORT_W-1:0] egress_port,
    output logic              drop,
    output logic [PORTS-1:0]  link_rpt,
    output logic [GROUPS-1:0] grp_up,
    output logic [GROUPS-1:0] led_n
);
    logic [1:0]        idx;
    logic [GROUPS-1:0] grp_fault;
    logic [GRP_W-1:0]  dst_grp;

    trunk_hash #(.ADDR_W(ADDR_W), .FOLD_BITS(8)) u_hash (
        .da(da), .sa(sa), .idx(idx)
    );

    trunk_health #(.GROUPS(GROUPS), .MEMBERS(MEMBERS)) u_health (
        .trunk_en(trunk_en), .link_up(link_up),
        .grp_up(grp_up), .grp_fault(grp_fault), .link_rpt(link_rpt)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_led
        trunk_led #(.BLINK_CYCLES(BLINK_CYCLES)) u_led (
            .clk(clk), .rst_n(rst_n), .en(trunk_en[g]),
            .fault(grp_fault[g]), .led_n(led_n[g])
        );
    end

    assign dst_grp = dst_port[PORT_W-1:MEM_W];

    always_comb begin
        egress_port = dst_port;
        drop        = 1'b0;
        if (trunk_en[dst_grp]) begin
            if (grp_fault[dst_grp]) drop = 1'b1;
            else egress_port = {dst_grp, MEM_W'(idx)};
        end
    end

    assert_same_group_R1: assert property (@(posedge clk) disable iff (!rst_n)
        egress_port[PORT_W-1:MEM_W] == dst_grp);
    assert_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !trunk_en[dst_grp] |-> (egress_port == dst_port && !drop));
    assert_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        drop |-> (egress_port == dst_port && !grp_up[dst_grp]));
    assert_fault_masks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (trunk_en[dst_grp] && !(&link_up[dst_grp*MEMBERS +: MEMBERS]))
            |-> (link_rpt[dst_grp*MEMBERS +: MEMBERS] == '0));
    assert_repeatable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(da) && $stable(sa) && $stable(dst_grp) && $stable(trunk_en)
         && $stable(link_up)) |-> $stable(egress_port));
endmodule

// File: tb/sim_trunk_port_selector.sv
`timescale 1ns/100ps
module sim_trunk_port_selector;
    localparam int N = 10;   // CLK_KHZ=1 * BLINK_MS=10

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  trunk_en = '0;
    logic [15:0] link_up = '1;
    logic [3:0]  dst_port = '0;
    logic [47:0] da = '0, sa = '0;
    logic [3:0]  egress_port;
    logic        drop;
    logic [15:0] link_rpt;
    logic [3:0]  grp_up, led_n;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    trunk_port_selector #(.CLK_KHZ(1), .BLINK_MS(10)) u0 (
        .clk(clk), .rst_n(rst_n), .trunk_en(trunk_en), .link_up(link_up),
        .dst_port(dst_port), .da(da), .sa(sa), .egress_port(egress_port),
        .drop(drop), .link_rpt(link_rpt), .grp_up(grp_up), .led_n(led_n)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] ref_idx(input logic [47:0] d, input logic [47:0] s);
        logic b0, b1;
        b0 = d[47]^d[45]^d[43]^d[41]^d[39]^d[37]^d[35]^d[33]
           ^ s[46]^s[44]^s[42]^s[40]^s[38]^s[36]^s[34]^s[32];
        b1 = s[47]^s[45]^s[43]^s[41]^s[39]^s[37]^s[35]^s[33]
           ^ d[46]^d[44]^d[42]^d[40]^d[38]^d[36]^d[34]^d[32];
        return {b1, b0};
    endfunction

    task automatic settle();
        @(negedge clk); #1;
    endtask

    task automatic t_reset();
        check("R8 reset led", led_n, 4'hF);
        check("R6 reset link_rpt", link_rpt, 16'hFFFF);
        check("R6 reset grp_up", grp_up, 4'h0);
    endtask

    task automatic t_hash();
        logic [47:0] pd[8], ps[8];
        trunk_en = 4'hF; link_up = '1;
        pd[0] = 48'h8000_0000_0000; ps[0] = '0;
        pd[1] = '0; ps[1] = 48'h8000_0000_0000;
        pd[2] = 48'h4000_0000_0000; ps[2] = '0;
        pd[3] = '0; ps[3] = 48'h0001_0000_0000;
        pd[4] = 48'h0000_FFFF_FFFF; ps[4] = 48'h0000_FFFF_FFFF;
        pd[5] = 48'h0123_4567_89AB; ps[5] = 48'hFEDC_BA98_7654;
        pd[6] = 48'hA5A5_0000_0000; ps[6] = 48'h3C00_1234_5678;
        pd[7] = 48'hFFFF_FFFF_FFFF; ps[7] = 48'h0200_0000_0000;
        for (int i = 0; i < 8; i++) begin
            da = pd[i]; sa = ps[i]; dst_port = 4'(4*(i%4) + (i%3));
            settle();
            check("R2 R3 R1 hash member", egress_port,
                  {dst_port[3:2], ref_idx(pd[i], ps[i])});
            check("R1 no drop", drop, 1'b0);
        end
        // single bits known results
        da = 48'h8000_0000_0000; sa = '0; dst_port = 4'd8; settle();
        check("R2 da47 -> idx1", egress_port, 4'd9);
        da = 48'h4000_0000_0000; sa = '0; settle();
        check("R3 da46 -> idx2", egress_port, 4'd10);
        da = '0; sa = 48'h0000_FFFF_FFFF; settle();
        check("R3 low bits ignored", egress_port, 4'd8);
    endtask

    task automatic t_consistency();
        trunk_en = 4'hF; link_up = '1;
        da = 48'h1234_5678_9ABC; sa = 48'hDEAD_BEEF_0042;
        for (int p = 4; p < 8; p++) begin
            dst_port = 4'(p); settle();
            check("R4 same member for pair", egress_port, {2'd1, ref_idx(da, sa)});
        end
    endtask

    task automatic t_bypass();
        trunk_en = 4'b0101; link_up = '1;
        da = 48'hFFFF_0000_0000; sa = 48'h5555_0000_0000;
        dst_port = 4'd6; settle();
        check("R5 disabled group pass", egress_port, 4'd6);
        check("R5 disabled no drop", drop, 1'b0);
        link_up = 16'hFF0F; dst_port = 4'd5; settle();
        check("R5 disabled faulty pass", {drop, egress_port}, {1'b0, 4'd5});
        check("R6 disabled link passthrough", link_rpt, 16'hFF0F);
        check("R6 disabled grp_up", grp_up[1], 1'b0);
    endtask

    task automatic t_health();
        trunk_en = 4'hF; link_up = 16'hFBFF;   // port 10 down
        da = 48'h8000_0000_0000; sa = '0; dst_port = 4'd9; settle();
        check("R6 group masked", link_rpt, 16'hF0FF);
        check("R6 grp_up", grp_up, 4'b1011);
        check("R7 drop flag", drop, 1'b1);
        check("R7 drop egress", egress_port, 4'd9);
        dst_port = 4'd13; settle();
        check("R7 other group ok", {drop, egress_port}, {1'b0, 4'd13});
        link_up = '1; settle();
        check("R6 recovered", link_rpt, 16'hFFFF);
    endtask

    task automatic t_led_levels();
        trunk_en = 4'b0011; link_up = '1;
        @(negedge clk); @(negedge clk); #1;
        check("R9 solid", led_n, 4'b1100);
        trunk_en = 4'b0001; @(negedge clk); #1;
        check("R8 disable dark", led_n, 4'b1110);
    endtask

    task automatic t_blink();
        int lit, dark, lit2;
        trunk_en = 4'b0001; link_up = '1;
        @(negedge clk); @(negedge clk);
        link_up = 16'hFFFD;   // port 1 down
        lit = 0; dark = 0; lit2 = 0;
        for (int k = 0; k < 3*N; k++) begin
            @(negedge clk); #1;
            if (k < N)        lit  += (led_n[0] == 1'b0);
            else if (k < 2*N) dark += (led_n[0] == 1'b1);
            else              lit2 += (led_n[0] == 1'b0);
        end
        check("R10 lit run", lit, N);
        check("R10 dark run", dark, N);
        check("R10 lit again", lit2, N);
        for (int k = 0; k < N/2; k++) @(negedge clk);
        #1; check("R10 mid dark", led_n[0], 1'b1);
        link_up = '1; @(negedge clk); #1;
        check("R11 recover solid", led_n[0], 1'b0);
        for (int k = 0; k < 2*N; k++) @(negedge clk);
        #1; check("R11 stays solid", led_n[0], 1'b0);
        link_up = 16'hFFFE; @(negedge clk); @(negedge clk);
        trunk_en = 4'b0000; @(negedge clk); #1;
        check("R8 blink to dark", led_n, 4'hF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1; t_reset();
        rst_n = 1'b1;
        t_hash();
        t_consistency();
        t_bypass();
        t_health();
        t_led_levels();
        t_blink();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule